// File: doc/BRIEF.md
# Operand and Branch-Target Address Resolver

This block sits beside the decode stage of an 8051-compatible core. It turns the raw fields of one decoded instruction into addresses. Its inputs are the address of the instruction's first byte, the instruction length, an operand-mode code, the opcode, up to two operand bytes, the register-bank select and the current contents of R0 and R1. Its outputs are the address of the following instruction, a branch or call target where the mode has one, and a data-memory address with a flag that tells direct RAM from SFR space.

Relative and short-absolute targets are formed from the address of the following instruction, not the current one. A short-absolute target therefore stays in the 2 kB page of the following instruction. Long targets are flagged when they leave the 8 kB program space. Every result passes through one register stage, and a valid strobe marks it one clock after the inputs are presented.

Top module: `mcs_addr_resolver`

## Requirements
- R1: `next_pc` equals `cur_pc + ins_len` modulo 2^16, for lengths 1 to 3.
- R2: Register mode (`op_mode` = 1) gives a RAM address of bank*8 + n, where n is `opcode[2:0]` and bank is `bank_sel`. `dmem_is_sfr` is 0.
- R3: Indirect mode (`op_mode` = 2) gives a RAM address taken from `r0_val` when `opcode[0]` = 0 and from `r1_val` when it is 1. The result is always RAM (`dmem_is_sfr` = 0), even for values of 0x80 and above.
- R4: Relative mode (`op_mode` = 4) gives a target of `next_pc` plus the sign-extended `opnd1`, modulo 2^16.
- R5: Short-absolute mode (`op_mode` = 5) gives a target of {`next_pc[15:11]`, `opcode[7:5]`, `opnd1`}, so the target lands in the 2 kB page of the following instruction.
- R6: Long mode (`op_mode` = 6) gives a target of {`opnd1`, `opnd2`}. `tgt_oor` is set exactly when that target is 0x2000 or above.
- R7: Direct mode (`op_mode` = 3) gives a data address equal to `opnd1`. `dmem_is_sfr` is 1 exactly when that address is 0x80 or above.
- R8: Opcode 0xA5 sets `is_nop` and only advances `next_pc`. Whatever the mode, `tgt_valid`, `tgt_oor` and `dmem_valid` stay 0 and both addresses read 0.
- R9: `out_valid` follows `in_valid` by exactly one clock. While `out_valid` is 0, every other output is 0.
- R10: A synchronous reset clears every output on the next clock edge, even if `in_valid` is high.
- R11: Mode codes 0 and 7 produce no target and no data address: the valid flags and both addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction fields are present this cycle |
| cur_pc | input | 16 | Address of the instruction's first byte |
| ins_len | input | 2 | Instruction length in bytes (1..3) |
| op_mode | input | 3 | Operand-mode code (0 none, 1 reg, 2 indirect, 3 direct, 4 relative, 5 short-absolute, 6 long, 7 none) |
| opcode | input | 8 | Opcode byte |
| opnd1 | input | 8 | First operand byte |
| opnd2 | input | 8 | Second operand byte |
| bank_sel | input | 2 | Register-bank select |
| r0_val | input | 8 | Current contents of R0 |
| r1_val | input | 8 | Current contents of R1 |
| out_valid | output | 1 | Results below are valid |
| next_pc | output | 16 | Address of the following instruction |
| tgt_valid | output | 1 | A branch target is present |
| tgt_pc | output | 16 | Branch or call target |
| tgt_oor | output | 1 | Long target lies outside program space |
| dmem_valid | output | 1 | A data address is present |
| dmem_addr | output | 8 | Data-memory address |
| dmem_is_sfr | output | 1 | The data address selects SFR space |
| is_nop | output | 1 | The opcode is the alternate no-operation |

## Verification
Every result is due exactly one rising edge after its inputs. The bench drives each vector on a falling edge and compares all outputs together on the next falling edge, after the single register has loaded and before anything else changes. For R9 and R10, the vector is followed by a cycle with `in_valid` low, or with reset asserted, and the outputs are sampled one falling edge later. Expected values are worked out by hand from the requirements, including the page crossing, the 16-bit wrap and the 0x7F/0x80 and 0x1FFF/0x2000 boundaries.

// File: rtl/mar_pkg.sv
`timescale 1ns/1ps
package mar_pkg;
   typedef enum logic [2:0] {
      OM_NONE  = 3'd0,
      OM_REG   = 3'd1,
      OM_IND   = 3'd2,
      OM_DIR   = 3'd3,
      OM_REL   = 3'd4,
      OM_ABS11 = 3'd5,
      OM_LONG  = 3'd6,
      OM_RSVD  = 3'd7
   } opmode_e;

   localparam logic [7:0] ALT_NOP_OPC = 8'hA5;
   localparam int         OPB_W       = 8;
   localparam int         REGSEL_W    = 3;
   localparam int         PAGE_HI_W   = 3;
endpackage

// File: rtl/mar_next_pc.sv
`timescale 1ns/1ps
module mar_next_pc #(
   parameter int PC_W  = 16,
   parameter int LEN_W = 2
) (
   input  logic [PC_W-1:0]  cur_pc,
   input  logic [LEN_W-1:0] ins_len,
   output logic [PC_W-1:0]  nxt_pc
);
   localparam int PAD_W = PC_W - LEN_W;

   if (PAD_W < 1) begin : g_bad_len
      $error("mar_next_pc: LEN_W must be narrower than PC_W");
   end

   always_comb begin
      nxt_pc = cur_pc + {{PAD_W{1'b0}}, ins_len};
   end
endmodule

// File: rtl/mar_branch.sv
`timescale 1ns/1ps
module mar_branch
   import mar_pkg::*;
#(
   parameter int PC_W    = 16,
   parameter int PROG_AW = 13
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [2:0]           mode,
   input  logic [PAGE_HI_W-1:0] opc_hi,
   input  logic [OPB_W-1:0]     b1,
   input  logic [OPB_W-1:0]     b2,
   input  logic [PC_W-1:0]      nxt_pc,
   output logic                 tgt_vld,
   output logic [PC_W-1:0]      tgt_pc,
   output logic                 tgt_oor
);
   localparam int PAGE_AW = PAGE_HI_W + OPB_W;
   localparam int SEXT_W  = PC_W - OPB_W;

   if (PC_W != 2 * OPB_W) begin : g_bad_pc
      $error("mar_branch: PC_W must equal two operand bytes");
   end
   if (PROG_AW > PC_W || PROG_AW < PAGE_AW) begin : g_bad_prog
      $error("mar_branch: PROG_AW out of range");
   end

   opmode_e          md;
   logic [PC_W-1:0]  rel_t;
   logic [PC_W-1:0]  abs_t;
   logic [PC_W-1:0]  long_t;
   logic             long_hi;

   assign md     = opmode_e'(mode);
   assign rel_t  = nxt_pc + {{SEXT_W{b1[OPB_W-1]}}, b1};
   assign abs_t  = {nxt_pc[PC_W-1:PAGE_AW], opc_hi, b1};
   assign long_t = {b1, b2};

   if (PROG_AW >= PC_W) begin : g_full_space
      assign long_hi = 1'b0;
   end else begin : g_part_space
      assign long_hi = |long_t[PC_W-1:PROG_AW];
   end

   always_comb begin
      tgt_vld = 1'b0;
      tgt_pc  = '0;
      tgt_oor = 1'b0;
      case (md)
         OM_REL: begin
            tgt_vld = 1'b1;
            tgt_pc  = rel_t;
         end
         OM_ABS11: begin
            tgt_vld = 1'b1;
            tgt_pc  = abs_t;
         end
         OM_LONG: begin
            tgt_vld = 1'b1;
            tgt_pc  = long_t;
            tgt_oor = long_hi;
         end
         default: ;
      endcase
   end

   // R5: short-absolute target shares the page of the following instruction
   assert_abs11_page_R5: assert property (@(posedge clk) disable iff (rst)
      (md == OM_ABS11) |-> (tgt_pc[PC_W-1:PAGE_AW] == nxt_pc[PC_W-1:PAGE_AW]));

   // R6: out-of-range flag only ever accompanies a long target
   assert_oor_long_R6: assert property (@(posedge clk) disable iff (rst)
      tgt_oor |-> (tgt_vld && md == OM_LONG));
endmodule

// File: rtl/mar_data_addr.sv
`timescale 1ns/1ps
module mar_data_addr
   import mar_pkg::*;
#(
   parameter int DM_AW  = 8,
   parameter int BANK_W = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [2:0]          mode,
   input  logic [REGSEL_W-1:0] reg_n,
   input  logic [BANK_W-1:0]   bank,
   input  logic [OPB_W-1:0]    b1,
   input  logic [DM_AW-1:0]    r0,
   input  logic [DM_AW-1:0]    r1,
   output logic                dm_vld,
   output logic [DM_AW-1:0]    dm_addr,
   output logic                dm_sfr
);
   localparam int REG_PAD = DM_AW - BANK_W - REGSEL_W;

   if (REG_PAD < 0) begin : g_bad_bank
      $error("mar_data_addr: register file does not fit the data space");
   end
   if (DM_AW != OPB_W) begin : g_bad_dm
      $error("mar_data_addr: DM_AW must equal the operand byte width");
   end

   opmode_e          md;
   logic [DM_AW-1:0] reg_addr;

   assign md = opmode_e'(mode);

   if (REG_PAD == 0) begin : g_reg_flush
      assign reg_addr = {bank, reg_n};
   end else begin : g_reg_pad
      assign reg_addr = {{REG_PAD{1'b0}}, bank, reg_n};
   end

   always_comb begin
      dm_vld  = 1'b0;
      dm_addr = '0;
      dm_sfr  = 1'b0;
      case (md)
         OM_REG: begin
            dm_vld  = 1'b1;
            dm_addr = reg_addr;
         end
         OM_IND: begin
            dm_vld  = 1'b1;
            dm_addr = reg_n[0] ? r1 : r0;
         end
         OM_DIR: begin
            dm_vld  = 1'b1;
            dm_addr = b1;
            dm_sfr  = b1[OPB_W-1];
         end
         default: ;
      endcase
   end

   // R3: register and indirect addressing never reach SFR space
   assert_ram_only_R3: assert property (@(posedge clk) disable iff (rst)
      (dm_vld && md != OM_DIR) |-> !dm_sfr);

   // R2: register addresses stay within the four banks of eight
   assert_reg_window_R2: assert property (@(posedge clk) disable iff (rst)
      (md == OM_REG) |-> (dm_addr < DM_AW'(1 << (BANK_W + REGSEL_W))));
endmodule

// File: rtl/mar_out_reg.sv
`timescale 1ns/1ps
module mar_out_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_vld,
   input  logic [W-1:0] d,
   output logic         q_vld,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("mar_out_reg: W must be positive");
   end

   logic past_ok;

   always_ff @(posedge clk) begin
      if (rst) begin
         q_vld <= 1'b0;
         q     <= '0;
      end else begin
         q_vld <= in_vld;
         q     <= in_vld ? d : '0;
      end
      past_ok <= !rst;
   end

   // R9: one-clock latency on the strobe
   assert_valid_lat_R9: assert property (@(posedge clk) disable iff (rst)
      past_ok |-> (q_vld == $past(in_vld)));

   // R9: payload is quiet whenever the strobe is low
   assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
      past_ok && !q_vld |-> (q == '0));
endmodule

// File: rtl/mcs_addr_resolver.sv
`timescale 1ns/1ps
module mcs_addr_resolver
   import mar_pkg::*;
#(
   parameter int PC_W    = 16,
   parameter int LEN_W   = 2,
   parameter int PROG_AW = 13,
   parameter int DM_AW   = 8,
   parameter int BANK_W  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [PC_W-1:0]   cur_pc,
   input  logic [LEN_W-1:0]  ins_len,
   input  logic [2:0]        op_mode,
   input  logic [7:0]        opcode,
   input  logic [7:0]        opnd1,
   input  logic [7:0]        opnd2,
   input  logic [BANK_W-1:0] bank_sel,
   input  logic [DM_AW-1:0]  r0_val,
   input  logic [DM_AW-1:0]  r1_val,
   output logic              out_valid,
   output logic [PC_W-1:0]   next_pc,
   output logic              tgt_valid,
   output logic [PC_W-1:0]   tgt_pc,
   output logic              tgt_oor,
   output logic              dmem_valid,
   output logic [DM_AW-1:0]  dmem_addr,
   output logic              dmem_is_sfr,
   output logic              is_nop
);
   localparam int RES_W = PC_W + 1 + PC_W + 1 + 1 + DM_AW + 1 + 1;

   logic [PC_W-1:0]  nxt;
   logic             b_vld, b_oor;
   logic [PC_W-1:0]  b_tgt;
   logic             d_vld, d_sfr;
   logic [DM_AW-1:0] d_addr;
   logic             nop_hit;
   logic [RES_W-1:0] res_d, res_q;

   mar_next_pc #(.PC_W(PC_W), .LEN_W(LEN_W)) u_npc (
      .cur_pc (cur_pc),
      .ins_len(ins_len),
      .nxt_pc (nxt)
   );

   mar_branch #(.PC_W(PC_W), .PROG_AW(PROG_AW)) u_br (
      .clk    (clk),
      .rst    (rst),
      .mode   (op_mode),
      .opc_hi (opcode[7:5]),
      .b1     (opnd1),
      .b2     (opnd2),
      .nxt_pc (nxt),
      .tgt_vld(b_vld),
      .tgt_pc (b_tgt),
      .tgt_oor(b_oor)
   );

   mar_data_addr #(.DM_AW(DM_AW), .BANK_W(BANK_W)) u_da (
      .clk    (clk),
      .rst    (rst),
      .mode   (op_mode),
      .reg_n  (opcode[2:0]),
      .bank   (bank_sel),
      .b1     (opnd1),
      .r0     (r0_val),
      .r1     (r1_val),
      .dm_vld (d_vld),
      .dm_addr(d_addr),
      .dm_sfr (d_sfr)
   );

   assign nop_hit = (opcode == ALT_NOP_OPC);

   always_comb begin
      if (nop_hit) begin
         res_d = {nxt, 1'b0, {PC_W{1'b0}}, 1'b0, 1'b0, {DM_AW{1'b0}}, 1'b0, 1'b1};
      end else begin
         res_d = {nxt, b_vld, b_tgt, b_oor, d_vld, d_addr, d_sfr, 1'b0};
      end
   end

   mar_out_reg #(.W(RES_W)) u_oreg (
      .clk   (clk),
      .rst   (rst),
      .in_vld(in_valid),
      .d     (res_d),
      .q_vld (out_valid),
      .q     (res_q)
   );

   assign {next_pc, tgt_valid, tgt_pc, tgt_oor,
           dmem_valid, dmem_addr, dmem_is_sfr, is_nop} = res_q;

   // R8: the alternate no-operation produces neither target nor data access
   assert_nop_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      (out_valid && is_nop) |-> (!tgt_valid && !dmem_valid && !tgt_oor));

   // R7: an SFR selection always carries a data address in the upper half
   assert_sfr_split_R7: assert property (@(posedge clk) disable iff (rst)
      dmem_is_sfr |-> (dmem_valid && dmem_addr[DM_AW-1]));

   // R6: out-of-range only with a target present
   assert_oor_tgt_R6: assert property (@(posedge clk) disable iff (rst)
      tgt_oor |-> tgt_valid);

   // R11: target and data address never appear together
   assert_single_kind_R11: assert property (@(posedge clk) disable iff (rst)
      !(tgt_valid && dmem_valid));
endmodule

// File: tb/mcs_addr_resolver_tb.sv
`timescale 1ns/1ps
module mcs_addr_resolver_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [15:0] cur_pc;
   logic [1:0]  ins_len;
   logic [2:0]  op_mode;
   logic [7:0]  opcode, opnd1, opnd2;
   logic [1:0]  bank_sel;
   logic [7:0]  r0_val, r1_val;
   logic        out_valid, tgt_valid, tgt_oor, dmem_valid, dmem_is_sfr, is_nop;
   logic [15:0] next_pc, tgt_pc;
   logic [7:0]  dmem_addr;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   mcs_addr_resolver u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .cur_pc(cur_pc),
      .ins_len(ins_len), .op_mode(op_mode), .opcode(opcode), .opnd1(opnd1),
      .opnd2(opnd2), .bank_sel(bank_sel), .r0_val(r0_val), .r1_val(r1_val),
      .out_valid(out_valid), .next_pc(next_pc), .tgt_valid(tgt_valid),
      .tgt_pc(tgt_pc), .tgt_oor(tgt_oor), .dmem_valid(dmem_valid),
      .dmem_addr(dmem_addr), .dmem_is_sfr(dmem_is_sfr), .is_nop(is_nop)
   );

   task automatic drive(input logic [15:0] pc, input logic [1:0] len,
                        input logic [2:0] md, input logic [7:0] opc,
                        input logic [7:0] a, input logic [7:0] b,
                        input logic [1:0] bk, input logic [7:0] x0,
                        input logic [7:0] x1);
      @(negedge clk);
      in_valid = 1'b1; cur_pc = pc; ins_len = len; op_mode = md;
      opcode = opc; opnd1 = a; opnd2 = b; bank_sel = bk; r0_val = x0; r1_val = x1;
      @(negedge clk);
   endtask

   task automatic expect_out(input string tag, input logic ov,
                             input logic [15:0] npc, input logic tv,
                             input logic [15:0] tpc, input logic oor,
                             input logic dv, input logic [7:0] da,
                             input logic sfr, input logic nop);
      logic [45:0] act, exp;
      act = {out_valid, next_pc, tgt_valid, tgt_pc, tgt_oor,
             dmem_valid, dmem_addr, dmem_is_sfr, is_nop};
      exp = {ov, npc, tv, tpc, oor, dv, da, sfr, nop};
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic t_reset;
      rst = 1'b1; in_valid = 1'b0; cur_pc = '0; ins_len = 2'd1; op_mode = '0;
      opcode = '0; opnd1 = '0; opnd2 = '0; bank_sel = '0; r0_val = '0; r1_val = '0;
      repeat (3) @(negedge clk);
      expect_out("R10 reset state", 0, 16'h0, 0, 16'h0, 0, 0, 8'h0, 0, 0);
      rst = 1'b0;
   endtask

   task automatic t_next_pc;
      drive(16'h1234, 2'd3, 3'd0, 8'h00, 8'h00, 8'h00, 2'd0, 8'h0, 8'h0);
      expect_out("R1 len3", 1, 16'h1237, 0, 16'h0, 0, 0, 8'h0, 0, 0);
      drive(16'hFFFF, 2'd2, 3'd0, 8'h00, 8'h00, 8'h00, 2'd0, 8'h0, 8'h0);
      expect_out("R1 wrap", 1, 16'h0001, 0, 16'h0, 0, 0, 8'h0, 0, 0);
      drive(16'h0040, 2'd1, 3'd0, 8'h00, 8'h00, 8'h00, 2'd0, 8'h0, 8'h0);
      expect_out("R1 len1", 1, 16'h0041, 0, 16'h0, 0, 0, 8'h0, 0, 0);
   endtask

   task automatic t_reg;
      drive(16'h0100, 2'd1, 3'd1, 8'h2D, 8'h00, 8'h00, 2'd2, 8'h0, 8'h0);
      expect_out("R2 bank2 r5", 1, 16'h0101, 0, 16'h0, 0, 1, 8'h15, 0, 0);
      drive(16'h0100, 2'd1, 3'd1, 8'hEF, 8'h00, 8'h00, 2'd3, 8'h0, 8'h0);
      expect_out("R2 bank3 r7", 1, 16'h0101, 0, 16'h0, 0, 1, 8'h1F, 0, 0);
   endtask

   task automatic t_ind;
      drive(16'h0200, 2'd1, 3'd2, 8'hE6, 8'h00, 8'h00, 2'd0, 8'h42, 8'h99);
      expect_out("R3 via r0", 1, 16'h0201, 0, 16'h0, 0, 1, 8'h42, 0, 0);
      drive(16'h0200, 2'd1, 3'd2, 8'hE7, 8'h00, 8'h00, 2'd0, 8'h42, 8'h99);
      expect_out("R3 via r1 high", 1, 16'h0201, 0, 16'h0, 0, 1, 8'h99, 0, 0);
   endtask

   task automatic t_direct;
      drive(16'h0300, 2'd2, 3'd3, 8'hE5, 8'h7F, 8'h00, 2'd0, 8'h0, 8'h0);
      expect_out("R7 0x7F ram", 1, 16'h0302, 0, 16'h0, 0, 1, 8'h7F, 0, 0);
      drive(16'h0300, 2'd2, 3'd3, 8'hE5, 8'h80, 8'h00, 2'd0, 8'h0, 8'h0);
      expect_out("R7 0x80 sfr", 1, 16'h0302, 0, 16'h0, 0, 1, 8'h80, 1, 0);
      drive(16'h0300, 2'd2, 3'd3, 8'hE5, 8'hFF, 8'h00, 2'd0, 8'h0, 8'h0);
      expect_out("R7 0xFF sfr", 1, 16'h0302, 0, 16'h0, 0, 1, 8'hFF, 1, 0);
   endtask

   task automatic t_rel;
      drive(16'h0100, 2'd2, 3'd4, 8'h80, 8'h10, 8'h00, 2'd0, 8'h0, 8'h0);
      expect_out("R4 forward", 1, 16'h0102, 1, 16'h0112, 0, 0, 8'h0, 0, 0);
      drive(16'h0100, 2'd2, 3'd4, 8'h80, 8'hFE, 8'h00, 2'd0, 8'h0, 8'h0);
      expect_out("R4 self loop", 1, 16'h0102, 1, 16'h0100, 0, 0, 8'h0, 0, 0);
      drive(16'h0000, 2'd2, 3'd4, 8'h80, 8'h80, 8'h00, 2'd0, 8'h0, 8'h0);
      expect_out("R4 wrap down", 1, 16'h0002, 1, 16'hFF82, 0, 0, 8'h0, 0, 0);
      drive(16'hFFFE, 2'd2, 3'd4, 8'h80, 8'h05, 8'h00, 2'd0, 8'h0, 8'h0);
      expect_out("R4 wrap up", 1, 16'h0000, 1, 16'h0005, 0, 0, 8'h0, 0, 0);
   endtask

   task automatic t_abs11;
      drive(16'h07FE, 2'd2, 3'd5, 8'h31, 8'h23, 8'h00, 2'd0, 8'h0, 8'h0);
      expect_out("R5 page cross", 1, 16'h0800, 1, 16'h0923, 0, 0, 8'h0, 0, 0);
      drive(16'h1000, 2'd2, 3'd5, 8'hE1, 8'hFF, 8'h00, 2'd0, 8'h0, 8'h0);
      expect_out("R5 page top", 1, 16'h1002, 1, 16'h17FF, 0, 0, 8'h0, 0, 0);
   endtask

   task automatic t_long;
      drive(16'h0010, 2'd3, 3'd6, 8'h02, 8'h1F, 8'hFF, 2'd0, 8'h0, 8'h0);
      expect_out("R6 in range", 1, 16'h0013, 1, 16'h1FFF, 0, 0, 8'h0, 0, 0);
      drive(16'h0010, 2'd3, 3'd6, 8'h02, 8'h20, 8'h00, 2'd0, 8'h0, 8'h0);
      expect_out("R6 out of range", 1, 16'h0013, 1, 16'h2000, 1, 0, 8'h0, 0, 0);
   endtask

   task automatic t_nop;
      drive(16'h0200, 2'd1, 3'd4, 8'hA5, 8'h10, 8'h00, 2'd0, 8'h0, 8'h0);
      expect_out("R8 nop rel", 1, 16'h0201, 0, 16'h0, 0, 0, 8'h0, 0, 1);
      drive(16'h0200, 2'd1, 3'd3, 8'hA5, 8'h90, 8'h00, 2'd0, 8'h0, 8'h0);
      expect_out("R8 nop direct", 1, 16'h0201, 0, 16'h0, 0, 0, 8'h0, 0, 1);
      drive(16'h0200, 2'd3, 3'd6, 8'hA5, 8'h30, 8'h00, 2'd0, 8'h0, 8'h0);
      expect_out("R8 nop long", 1, 16'h0203, 0, 16'h0, 0, 0, 8'h0, 0, 1);
   endtask

   task automatic t_none_modes;
      drive(16'h0500, 2'd2, 3'd7, 8'h11, 8'h90, 8'h33, 2'd1, 8'h55, 8'h66);
      expect_out("R11 mode7", 1, 16'h0502, 0, 16'h0, 0, 0, 8'h0, 0, 0);
      drive(16'h0500, 2'd2, 3'd0, 8'h11, 8'h90, 8'h33, 2'd1, 8'h55, 8'h66);
      expect_out("R11 mode0", 1, 16'h0502, 0, 16'h0, 0, 0, 8'h0, 0, 0);
   endtask

   task automatic t_idle;
      drive(16'h0100, 2'd2, 3'd4, 8'h80, 8'h10, 8'h00, 2'd0, 8'h0, 8'h0);
      in_valid = 1'b0;
      @(negedge clk);
      expect_out("R9 idle clears", 0, 16'h0, 0, 16'h0, 0, 0, 8'h0, 0, 0);
      @(negedge clk);
      in_valid = 1'b1; cur_pc = 16'h0020; ins_len = 2'd1; op_mode = 3'd3; opnd1 = 8'hA0;
      @(negedge clk);
      expect_out("R9 one cycle", 1, 16'h0021, 0, 16'h0, 0, 1, 8'hA0, 1, 0);
   endtask

   task automatic t_reset_mid;
      drive(16'h0010, 2'd3, 3'd6, 8'h02, 8'h20, 8'h00, 2'd0, 8'h0, 8'h0);
      rst = 1'b1;
      @(negedge clk);
      expect_out("R10 reset over valid", 0, 16'h0, 0, 16'h0, 0, 0, 8'h0, 0, 0);
      rst = 1'b0; in_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_next_pc();
      t_reg();
      t_ind();
      t_direct();
      t_rel();
      t_abs11();
      t_long();
      t_nop();
      t_none_modes();
      t_idle();
      t_reset_mid();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule